// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block records the calendar time at the moment an external tamper or trigger input fires. The running time arrives on a bus of six BCD fields: seconds, minutes, hours, day of month, month and year. When a qualified event arrives, the block latches a masked copy of that bus into six read-only registers. It also sets two event flags, which live in two separate control registers. Software reaches the control bits, the flags and the captured time through a simple register read/write port. An active-low interrupt request tells software that a flag is pending.

Two capture policies are available. The overwrite policy lets every new event replace the stored time. The first-event policy locks the stored time while either flag is set, so the earliest event is kept until software clears both flags. A disable bit blocks capture entirely. Flags clear when software writes 0 to their bit positions. Writing 1 to a flag bit leaves it unchanged, so a read-modify-write of the other bits in the same register does not lose a pending event.

Top module: `tamper_stamp`

## Requirements
- R1: After reset, every register reads 0 and `irqN` is high.
- R2: A rising edge on `trigIn` is passed through a two-flop synchronizer and an edge detector. The capture then happens on the third rising clock edge after `trigIn` goes high. It sets flag A (register 0x00 bit 4) and flag B (register 0x01 bit 5). A trigger held high produces exactly one capture.
- R3: The captured fields occupy registers 0x13 to 0x18 in this order: seconds, minutes, hours, day, month, year. `liveTime[7:0]` holds seconds and `liveTime[47:40]` holds year. Seconds and minutes keep 7 bits, hours and day keep 6, month keeps 5 and year keeps 8. All unused upper bits read 0.
- R4: When register 0x12 bit 6 is 1, trigger events change neither the captured registers nor the flags.
- R5: When register 0x12 bit 7 is 0, every event overwrites the captured registers, even if the flags are still set.
- R6: When register 0x12 bit 7 is 1 and either flag is set, events leave both the captured registers and the flags unchanged. Once both flags are clear, the next event captures again.
- R7: Writing 0 to a flag bit clears that flag, and writing 1 to it leaves the flag unchanged. The only writable control bits are 0x01 bit 2 (interrupt enable) and 0x12 bits 6 and 7. Every other bit of 0x00, 0x01 and 0x12 reads 0.
- R8: `irqN` is low exactly when the interrupt enable is 1 and at least one flag is set. It follows the register values without added delay.
- R9: If a capture and a flag-clear write fall on the same clock edge, the capture wins and the flag ends up set.
- R10: `regRdata` is a combinational function of `regAddr`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Asynchronous tamper/trigger input, active high |
| liveTime | input | 48 | Running time, six BCD bytes, seconds in the low byte |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address for read and write |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `liveTime` is stable around each capture edge. They also assume that `trigIn`, although asynchronous, stays high for at least two clock periods, so the synchronizer sees it. The stimulus holds the time bus constant during every trigger pulse and keeps each pulse several cycles long. It drives register writes one clock after an edge, so each write lands on a single known edge. The one deliberate collision places a flag-clear write exactly on the capture edge.

// File: rtl/tamper_stamp_pkg.sv
package tamper_stamp_pkg;

  localparam int NUM_FIELDS = 6;

  localparam int ADDR_CTL_A      = 'h00;
  localparam int ADDR_CTL_B      = 'h01;
  localparam int ADDR_STAMP_CTL  = 'h12;
  localparam int ADDR_STAMP_BASE = 'h13;

  localparam int BIT_FLAG_A = 4;
  localparam int BIT_FLAG_B = 5;
  localparam int BIT_IRQ_EN = 2;
  localparam int BIT_OFF    = 6;
  localparam int BIT_FIRST  = 7;

  typedef struct packed {
    logic capture;
  } stampStrobe_t;

  typedef struct packed {
    logic flagA;
    logic flagB;
    logic irqEn;
    logic stampOff;
    logic firstMode;
  } ctlView_t;

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      0, 1:    fieldMask = 8'h7F;
      2, 3:    fieldMask = 8'h3F;
      4:       fieldMask = 8'h1F;
      default: fieldMask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_stamp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output stampStrobe_t      strobe,
  output ctlView_t          view
);
  logic syncOut, syncDly, edgeSeen, locked;
  logic wrA, wrB, wrS;
  logic flagA, flagB, irqEn, stampOff, firstMode;
  logic unusedWdata;

  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (trigIn),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncDly <= 1'b0;
    else       syncDly <= syncOut;
  end

  assign edgeSeen = syncOut & ~syncDly;
  assign locked   = firstMode & (flagA | flagB);

  assign wrA = regWe && (regAddr == ADDR_W'(ADDR_CTL_A));
  assign wrB = regWe && (regAddr == ADDR_W'(ADDR_CTL_B));
  assign wrS = regWe && (regAddr == ADDR_W'(ADDR_STAMP_CTL));

  assign strobe.capture = edgeSeen & ~stampOff & ~locked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA     <= 1'b0;
      flagB     <= 1'b0;
      irqEn     <= 1'b0;
      stampOff  <= 1'b0;
      firstMode <= 1'b0;
    end else begin
      if (strobe.capture)                    flagA <= 1'b1;
      else if (wrA && !regWdata[BIT_FLAG_A]) flagA <= 1'b0;

      if (strobe.capture)                    flagB <= 1'b1;
      else if (wrB && !regWdata[BIT_FLAG_B]) flagB <= 1'b0;

      if (wrB) irqEn <= regWdata[BIT_IRQ_EN];
      if (wrS) begin
        stampOff  <= regWdata[BIT_OFF];
        firstMode <= regWdata[BIT_FIRST];
      end
    end
  end

  assign view.flagA     = flagA;
  assign view.flagB     = flagB;
  assign view.irqEn     = irqEn;
  assign view.stampOff  = stampOff;
  assign view.firstMode = firstMode;

  assign unusedWdata = ^regWdata;
endmodule

// File: rtl/tamper_data.sv
module tamper_data
  import tamper_stamp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int BUS_W = NUM_FIELDS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stampStrobe_t      strobe,
  input  ctlView_t          view,
  input  logic [BUS_W-1:0]  liveTime,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdata,
  output logic [BUS_W-1:0]  stampBus
);
  logic [DATA_W-1:0] stampQ [NUM_FIELDS];

  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      localparam logic [DATA_W-1:0] MASK = DATA_W'(fieldMask(i));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               stampQ[i] <= '0;
        else if (strobe.capture) stampQ[i] <= liveTime[i*DATA_W +: DATA_W] & MASK;
      end
      assign stampBus[i*DATA_W +: DATA_W] = stampQ[i];
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_CTL_A)) begin
      regRdata[BIT_FLAG_A] = view.flagA;
    end else if (regAddr == ADDR_W'(ADDR_CTL_B)) begin
      regRdata[BIT_FLAG_B] = view.flagB;
      regRdata[BIT_IRQ_EN] = view.irqEn;
    end else if (regAddr == ADDR_W'(ADDR_STAMP_CTL)) begin
      regRdata[BIT_OFF]   = view.stampOff;
      regRdata[BIT_FIRST] = view.firstMode;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (regAddr == ADDR_W'(ADDR_STAMP_BASE + i)) regRdata = stampQ[i];
      end
    end
  end
endmodule

// File: rtl/tamper_stamp.sv
module tamper_stamp
  import tamper_stamp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         trigIn,
  input  logic [NUM_FIELDS*DATA_W-1:0] liveTime,
  input  logic                         regWe,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWdata,
  output logic [DATA_W-1:0]            regRdata,
  output logic                         irqN
);
  stampStrobe_t                 strobe;
  ctlView_t                     view;
  logic [NUM_FIELDS*DATA_W-1:0] stampBus;

  tamper_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigIn  (trigIn),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .strobe  (strobe),
    .view    (view)
  );

  tamper_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .view    (view),
    .liveTime(liveTime),
    .regAddr (regAddr),
    .regRdata(regRdata),
    .stampBus(stampBus)
  );

  assign irqN = ~(view.irqEn & (view.flagA | view.flagB));
endmodule

// File: rtl/tamper_stamp_chk.sv
module tamper_stamp_chk
  import tamper_stamp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         regWe,
  input logic [ADDR_W-1:0]            regAddr,
  input logic                         wdFlagA,
  input logic                         wdFlagB,
  input logic [DATA_W-1:0]            regRdata,
  input logic                         irqN,
  input stampStrobe_t                 strobe,
  input ctlView_t                     view,
  input logic [NUM_FIELDS*DATA_W-1:0] stampBus
);
  AST_CAPTURE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (view.flagA && view.flagB)); // R2

  AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture); // R2

  AST_HOUR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_STAMP_BASE + 2)) |-> ((regRdata & 8'hC0) == 8'h00)); // R3

  AST_MONTH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_STAMP_BASE + 4)) |-> ((regRdata & 8'hE0) == 8'h00)); // R3

  AST_OFF_HOLDS_STAMP: assert property (@(posedge clk) disable iff (!rstN)
    view.stampOff |=> $stable(stampBus)); // R4

  AST_LOCK_HOLDS_STAMP: assert property (@(posedge clk) disable iff (!rstN)
    (view.firstMode && (view.flagA || view.flagB)) |=> $stable(stampBus)); // R6

  AST_FLAGA_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(view.flagA) |-> $past(regWe && regAddr == ADDR_W'(ADDR_CTL_A) && !wdFlagA)); // R7

  AST_FLAGB_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(view.flagB) |-> $past(regWe && regAddr == ADDR_W'(ADDR_CTL_B) && !wdFlagB)); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> ((view.flagA || view.flagB) && view.irqEn)); // R8

  AST_CAPTURE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> view.flagA); // R9
endmodule

bind tamper_stamp tamper_stamp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .wdFlagA (regWdata[4]),
  .wdFlagB (regWdata[5]),
  .regRdata(regRdata),
  .irqN    (irqN),
  .strobe  (strobe),
  .view    (view),
  .stampBus(stampBus)
);

// File: tb/tamper_stamp_bench.sv
`timescale 1ns/1ps
module tamper_stamp_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigIn = 1'b0;
  logic [47:0] liveTime = '0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        irqN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int         expAddrQ[$];
  logic [7:0] expValQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  tamper_stamp u_tamper_stamp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .liveTime(liveTime),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqN(irqN)
  );

  // monitor: pop one expected item per cycle, compare away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (expAddrQ.size() > 0) begin
        int a;
        logic [7:0] e, act;
        string t;
        a = expAddrQ.pop_front();
        e = expValQ.pop_front();
        t = tagQ.pop_front();
        act = (a < 0) ? {7'b0, irqN} : regRdata;
        checks++;
        if (act !== e) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, a, act, e);
        end
      end
    end
  end

  task automatic chkReg(input int a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    regAddr = a[4:0];
    expAddrQ.push_back(a); expValQ.push_back(e); tagQ.push_back(t);
  endtask

  task automatic chkIrq(input logic e, input string t);
    @(posedge clk); #1;
    expAddrQ.push_back(-1); expValQ.push_back({7'b0, e}); tagQ.push_back(t);
  endtask

  task automatic wrReg(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a[4:0]; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic pulse();
    @(posedge clk); #1 trigIn = 1'b1;
    repeat (5) @(posedge clk);
    #1 trigIn = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic setTime(input logic [7:0] s, mi, h, d, mo, y);
    liveTime = {y, mo, d, h, mi, s};
  endtask

  task automatic chkStamp(input logic [7:0] s, mi, h, d, mo, y, input string t);
    chkReg('h13, s, t);  chkReg('h14, mi, t); chkReg('h15, h, t);
    chkReg('h16, d, t);  chkReg('h17, mo, t); chkReg('h18, y, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chkReg('h00, 8'h00, "R1"); chkReg('h01, 8'h00, "R1"); chkReg('h12, 8'h00, "R1");
    chkStamp(0, 0, 0, 0, 0, 0, "R1");
    chkIrq(1'b1, "R1");

    // R7 / R8 enable interrupt, no flag yet
    wrReg('h01, 8'h04);
    chkReg('h01, 8'h04, "R7");
    chkIrq(1'b1, "R8");

    // R2 / R3 capture with junk in upper bits
    setTime(8'hD9, 8'hB4, 8'hE3, 8'hF1, 8'hF2, 8'h99);
    pulse();
    chkStamp(8'h59, 8'h34, 8'h23, 8'h31, 8'h12, 8'h99, "R3");
    chkReg('h00, 8'h10, "R2"); chkReg('h01, 8'h24, "R2");
    chkIrq(1'b0, "R8");

    // R7 write 1 keeps, write 0 clears
    wrReg('h00, 8'hFF);
    chkReg('h00, 8'h10, "R7");
    wrReg('h01, 8'h04);
    chkReg('h01, 8'h04, "R7");
    chkIrq(1'b0, "R8");
    wrReg('h00, 8'h00);
    chkReg('h00, 8'h00, "R7");
    chkIrq(1'b1, "R8");

    // R5 overwrite mode, second event with flags still set
    setTime(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06);
    pulse();
    chkStamp(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, "R5");
    setTime(8'h10, 8'h11, 8'h12, 8'h13, 8'h11, 8'h14);
    pulse();
    chkStamp(8'h10, 8'h11, 8'h12, 8'h13, 8'h11, 8'h14, "R5");

    // R2 held trigger captures once
    @(posedge clk); #1 trigIn = 1'b1;
    setTime(8'h21, 8'h22, 8'h21, 8'h22, 8'h09, 8'h23);
    repeat (5) @(posedge clk);
    #1 setTime(8'h45, 8'h46, 8'h17, 8'h18, 8'h10, 8'h47);
    repeat (5) @(posedge clk);
    #1 trigIn = 1'b0;
    repeat (3) @(posedge clk);
    chkStamp(8'h21, 8'h22, 8'h21, 8'h22, 8'h09, 8'h23, "R2");

    // R6 first-event lock
    wrReg('h12, 8'h80);
    setTime(8'h30, 8'h31, 8'h10, 8'h15, 8'h07, 8'h24);
    pulse();
    chkStamp(8'h21, 8'h22, 8'h21, 8'h22, 8'h09, 8'h23, "R6");
    wrReg('h00, 8'h00);
    pulse();
    chkReg('h13, 8'h21, "R6");
    chkReg('h00, 8'h00, "R6"); chkReg('h01, 8'h24, "R6");
    wrReg('h01, 8'h04);
    pulse();
    chkStamp(8'h30, 8'h31, 8'h10, 8'h15, 8'h07, 8'h24, "R6");
    chkReg('h00, 8'h10, "R6");

    // R4 disabled
    wrReg('h12, 8'h40);
    wrReg('h00, 8'h00); wrReg('h01, 8'h04);
    setTime(8'h55, 8'h55, 8'h05, 8'h05, 8'h05, 8'h55);
    pulse();
    chkStamp(8'h30, 8'h31, 8'h10, 8'h15, 8'h07, 8'h24, "R4");
    chkReg('h00, 8'h00, "R4"); chkReg('h01, 8'h04, "R4");
    chkIrq(1'b1, "R4");
    chkReg('h12, 8'h40, "R7");

    // R7 only bits 6 and 7 of the stamp control hold
    wrReg('h12, 8'hFF);
    chkReg('h12, 8'hC0, "R7");
    wrReg('h12, 8'h00);

    // R9 capture coincides with flag clear write
    @(posedge clk); #1 trigIn = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = 5'h00; regWdata = 8'h00;
    @(posedge clk); #1 regWe = 1'b0;
    repeat (3) @(posedge clk); #1 trigIn = 1'b0;
    chkReg('h00, 8'h10, "R9");
    chkReg('h13, 8'h55, "R9");

    // R10 unmapped addresses
    chkReg('h05, 8'h00, "R10"); chkReg('h1F, 8'h00, "R10"); chkReg('h19, 8'h00, "R10");

    repeat (4) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule